// File: doc/BRIEF.md
# Dual Program-Bus Fetch Steering Controller

This block sits between a CPU's instruction-fetch sequencer and two external program-memory buses. Each bus carries a multiplexed low address/data byte and a dedicated high address byte. Two strap inputs select the routing. One is a bus-enable strap for the alternate bus; the other is an external-access strap. In one strap setting the fetch address also takes part, and the decision there is made on address bits 15..13. The block runs continuously. Each 12-clock machine cycle holds two 6-clock fetch slots. In each slot it puts out the address, pulses the address-latch strobe, drives the active-low read strobe of the selected bus, and captures the opcode byte returned on that bus's low port.

An upstream sequencer supplies the next fetch address, together with a flag that marks a machine cycle as carrying an external data-memory access. Data accesses use the primary bus only, so in a flagged cycle the second fetch slot is dropped. The straps are taken while reset is held. When the alternate bus is not enabled, its two ports act as plain byte-wide output registers that are written through a small register port.

Top module: `fsteer_top`

## Requirements
- R1: With straps bus_en=0, ext_acc=0, every fetch address uses the primary bus: pri_rd_n pulses and alt_rd_n stays high.
- R2: Straps bus_en=0, ext_acc=1 are invalid: strap_bad is 1, and ale, both read strobes and fetch_valid stay inactive.
- R3: With straps bus_en=1, ext_acc=0, every fetch address uses the alternate bus: alt_rd_n pulses and pri_rd_n stays high.
- R4: With both straps 1, addresses whose bits 15..13 are all zero (below 2000H) use the alternate bus, and all other addresses use the primary bus.
- R5: In each active slot, counting the clocks of the slot from 0 to 5, ale is high on clocks 0–1 and the selected read strobe is low on clocks 3–5. During the slot the selected bus shows the address low byte on its lo port and the high byte on its hi port. No more than one read strobe is low at a time, and no read strobe is low while ale is high.
- R6: A machine cycle is two slots of 6 clocks, and the first slot starts on the first clock after reset. data_cycle is sampled at the start of each machine cycle. When it is 1, the second slot of that cycle has no ale, no read strobe and no fetch_valid.
- R7: On the last clock of an active slot, the selected bus's lo_in byte is captured. On the next clock fetch_valid is high for one clock, with fetch_data holding that byte and fetch_tag holding the slot's address.
- R8: The straps are sampled while rst_n is low and held after release. Changes on the strap pins while running have no effect.
- R9: With bus_en strapped 0, a register write to 91H sets alt_lo_out and a write to A1H sets alt_hi_out, starting the clock after the write. Writes to other addresses change neither. sfr_rdata returns the addressed register. Both registers reset to FFH.
- R10: During reset, ale=0, pri_rd_n=alt_rd_n=1 and fetch_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Alternate-bus enable strap |
| ext_acc | input | 1 | External-access strap |
| next_addr | input | 16 | Address of the next fetch, taken at each slot start |
| data_cycle | input | 1 | Next machine cycle carries a data access |
| pri_lo_in | input | 8 | Byte returned on the primary low port |
| alt_lo_in | input | 8 | Byte returned on the alternate low port |
| sfr_we | input | 1 | Port-register write enable |
| sfr_addr | input | 8 | Port-register address |
| sfr_wdata | input | 8 | Port-register write data |
| sfr_rdata | output | 8 | Port-register read data |
| pri_lo_out | output | 8 | Primary low address byte |
| pri_hi_out | output | 8 | Primary high address byte |
| alt_lo_out | output | 8 | Alternate low address byte or register |
| alt_hi_out | output | 8 | Alternate high address byte or register |
| ale | output | 1 | Address-latch strobe, active high |
| pri_rd_n | output | 1 | Primary program read strobe, active low |
| alt_rd_n | output | 1 | Alternate program read strobe, active low |
| strap_bad | output | 1 | Invalid strap combination |
| fetch_valid | output | 1 | Opcode byte captured |
| fetch_data | output | 8 | Captured opcode byte |
| fetch_tag | output | 16 | Address of the captured byte |

## Verification
The assertions watch, on every cycle, the rules that hold regardless of the traffic. Strobes stay mutually exclusive, ale never overlaps a read, and the alternate strobe needs the enable strap. An invalid strap setting must keep everything silent, and the held straps must not move. The slot counter must wrap, fetch_valid may only follow a read strobe, and register writes must land. Only the bench scenarios can show the routing decision for each strap setting and for addresses on both sides of 2000H, the clock-exact strobe positions, the skipped second slot, and the opcode and tag values that come back.

// File: rtl/fsteer_pkg.sv
// Shared types for the fetch steering controller.
package fsteer_pkg;
    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_PRI  = 2'd1,
        BUS_ALT  = 2'd2
    } bus_sel_t;
endpackage

// File: rtl/fsteer_timer.sv
// Slot timer: counts clocks within a fetch slot and tracks which of the two
// slots of a machine cycle is running. Assumes SLOT_CLKS >= 4.
// Reset parks it on the last clock of a second slot, so the first clock after
// release opens slot 0 of a fresh machine cycle.
module fsteer_timer #(
    parameter int SLOT_CLKS = 6,
    localparam int SW = $clog2(SLOT_CLKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] sub,
    output logic          second_slot,
    output logic          slot_end,
    output logic          cycle_end
);
    localparam logic [SW-1:0] LAST = SW'(SLOT_CLKS - 1);

    assign slot_end  = (sub == LAST);
    assign cycle_end = slot_end && second_slot;

    // Advance the in-slot clock count and flip slots on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub         <= LAST;
            second_slot <= 1'b1;
        end else if (slot_end) begin
            sub         <= '0;
            second_slot <= ~second_slot;
        end else begin
            sub <= sub + 1'b1;
        end
    end

    AST_SUB_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sub == LAST) |=> (sub == '0)); // R6
    AST_SLOT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (sub == LAST) |=> (second_slot != $past(second_slot))); // R6
endmodule

// File: rtl/fsteer_route.sv
// Route decoder: picks the bus for a fetch address from the held straps.
// Purely combinational; addresses whose bits above SPLIT_BIT-1 are zero count
// as "low" when both straps are set.
module fsteer_route
    import fsteer_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SPLIT_BIT = 13
) (
    input  logic              bus_en,
    input  logic              ext_acc,
    input  logic [ADDR_W-1:0] addr,
    output bus_sel_t          sel,
    output logic              bad
);
    // Map strap pair plus address to a bus choice.
    always_comb begin
        bad = !bus_en && ext_acc;
        if (bad)
            sel = BUS_NONE;
        else if (!bus_en)
            sel = BUS_PRI;
        else if (!ext_acc)
            sel = BUS_ALT;
        else if (addr[ADDR_W-1:SPLIT_BIT] == '0)
            sel = BUS_ALT;
        else
            sel = BUS_PRI;
    end
endmodule

// File: rtl/fsteer_portregs.sv
// Port registers for the alternate bus when it is used as plain output.
// Two byte registers at fixed register addresses, reset to all ones.
module fsteer_portregs #(
    parameter logic [7:0] LO_ADDR = 8'h91,
    parameter logic [7:0] HI_ADDR = 8'hA1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] lo_q,
    output logic [7:0] hi_q
);
    // Latch register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= 8'hFF;
            hi_q <= 8'hFF;
        end else if (we) begin
            if (addr == LO_ADDR) lo_q <= wdata;
            if (addr == HI_ADDR) hi_q <= wdata;
        end
    end

    // Select read data by address.
    always_comb begin
        if (addr == LO_ADDR)      rdata = lo_q;
        else if (addr == HI_ADDR) rdata = hi_q;
        else                      rdata = 8'h00;
    end

    AST_LO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == LO_ADDR) |=> (lo_q == $past(wdata))); // R9
    AST_HI_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == HI_ADDR) |=> $stable(hi_q)); // R9
endmodule

// File: rtl/fsteer_top.sv
// Fetch steering controller top. Holds the straps taken during reset, runs
// two fetch slots per machine cycle, drives the selected bus's address bytes
// and strobes, and captures the returned opcode with its address.
// Assumes next_addr is valid on the last clock of each slot and data_cycle on
// the last clock of each machine cycle.
module fsteer_top
    import fsteer_pkg::*;
#(
    parameter int         ADDR_W    = 16,
    parameter int         SLOT_CLKS = 6,
    parameter int         SPLIT_BIT = 13,
    parameter logic [7:0] LO_SFR    = 8'h91,
    parameter logic [7:0] HI_SFR    = 8'hA1,
    localparam int        HI_W      = ADDR_W - 8,
    localparam int        SW        = $clog2(SLOT_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              ext_acc,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic              data_cycle,
    input  logic [7:0]        pri_lo_in,
    input  logic [7:0]        alt_lo_in,
    input  logic              sfr_we,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    output logic [7:0]        pri_lo_out,
    output logic [HI_W-1:0]   pri_hi_out,
    output logic [7:0]        alt_lo_out,
    output logic [HI_W-1:0]   alt_hi_out,
    output logic              ale,
    output logic              pri_rd_n,
    output logic              alt_rd_n,
    output logic              strap_bad,
    output logic              fetch_valid,
    output logic [7:0]        fetch_data,
    output logic [ADDR_W-1:0] fetch_tag
);
    logic              en_q, ea_q, run_q, skip_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [SW-1:0]     sub;
    logic              second_slot, slot_end, cycle_end;
    bus_sel_t          sel;
    logic              active, in_ale, in_rd;
    logic [7:0]        reg_lo, reg_hi;

    fsteer_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .sub(sub), .second_slot(second_slot),
        .slot_end(slot_end), .cycle_end(cycle_end)
    );

    fsteer_route #(.ADDR_W(ADDR_W), .SPLIT_BIT(SPLIT_BIT)) u_route (
        .bus_en(en_q), .ext_acc(ea_q), .addr(cur_addr), .sel(sel), .bad(strap_bad)
    );

    fsteer_portregs #(.LO_ADDR(LO_SFR), .HI_ADDR(HI_SFR)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr),
        .wdata(sfr_wdata), .rdata(sfr_rdata), .lo_q(reg_lo), .hi_q(reg_hi)
    );

    // Take straps while reset is held; keep them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= bus_en;
            ea_q <= ext_acc;
        end
    end

    // Load the slot address, the data-cycle skip flag, and the run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            skip_q   <= 1'b0;
            cur_addr <= '0;
        end else begin
            run_q <= 1'b1;
            if (slot_end)  cur_addr <= next_addr;
            if (cycle_end) skip_q   <= data_cycle;
        end
    end

    assign active = run_q && !strap_bad && !(second_slot && skip_q);
    assign in_ale = active && (sub < SW'(2));
    assign in_rd  = active && (sub >= SW'(3));

    // Strobes for the slot.
    always_comb begin
        ale      = in_ale;
        pri_rd_n = !(in_rd && sel == BUS_PRI);
        alt_rd_n = !(in_rd && sel == BUS_ALT);
    end

    // Address bytes: selected bus shows the address, others idle high; the
    // alternate ports fall back to their registers when not enabled.
    always_comb begin
        pri_lo_out = 8'hFF;
        pri_hi_out = '1;
        alt_lo_out = 8'hFF;
        alt_hi_out = '1;
        if (active && sel == BUS_PRI) begin
            pri_lo_out = cur_addr[7:0];
            pri_hi_out = cur_addr[ADDR_W-1:8];
        end
        if (!en_q) begin
            alt_lo_out = reg_lo;
            alt_hi_out = HI_W'(reg_hi);
        end else if (active && sel == BUS_ALT) begin
            alt_lo_out = cur_addr[7:0];
            alt_hi_out = cur_addr[ADDR_W-1:8];
        end
    end

    // Capture the returned opcode at slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
            fetch_data  <= '0;
            fetch_tag   <= '0;
        end else begin
            fetch_valid <= slot_end && active;
            if (slot_end && active) begin
                fetch_data <= (sel == BUS_ALT) ? alt_lo_in : pri_lo_in;
                fetch_tag  <= cur_addr;
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!pri_rd_n && !alt_rd_n)); // R5
    AST_ALE_NOT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (pri_rd_n && alt_rd_n)); // R5
    AST_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        strap_bad |-> (pri_rd_n && alt_rd_n && !ale && !fetch_valid)); // R2
    AST_ALT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_rd_n |-> en_q); // R3
    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> ($stable(en_q) && $stable(ea_q))); // R8
    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> $past(!pri_rd_n || !alt_rd_n)); // R7
endmodule

// File: tb/test_fsteer_top.sv
module test_fsteer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, ext_acc = 1'b0;
    logic [15:0] next_addr = '0;
    logic        data_cycle = 1'b0;
    logic [7:0]  pri_lo_in = '0, alt_lo_in = '0;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = '0, sfr_wdata = '0;
    logic [7:0]  sfr_rdata, pri_lo_out, pri_hi_out, alt_lo_out, alt_hi_out;
    logic        ale, pri_rd_n, alt_rd_n, strap_bad, fetch_valid;
    logic [7:0]  fetch_data;
    logic [15:0] fetch_tag;

    int total = 0;
    int bad   = 0;
    logic exp_en, exp_ea, slot_par, skip_exp, mon_en;
    logic [23:0] sb_q[$];

    always #2 clk = ~clk;

    fsteer_top i_fsteer_top (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .ext_acc(ext_acc),
        .next_addr(next_addr), .data_cycle(data_cycle),
        .pri_lo_in(pri_lo_in), .alt_lo_in(alt_lo_in),
        .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .pri_lo_out(pri_lo_out), .pri_hi_out(pri_hi_out),
        .alt_lo_out(alt_lo_out), .alt_hi_out(alt_hi_out), .ale(ale),
        .pri_rd_n(pri_rd_n), .alt_rd_n(alt_rd_n), .strap_bad(strap_bad),
        .fetch_valid(fetch_valid), .fetch_data(fetch_data), .fetch_tag(fetch_tag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] op_pri(input logic [15:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] op_alt(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hC3;
    endfunction

    // Monitor: pop the expected fetch and compare tag and data.
    always @(negedge clk) begin
        if (rst_n && mon_en && fetch_valid) begin
            if (sb_q.size() == 0) begin
                check("R6 unexpected fetch_valid", {16'h0, fetch_tag}, 32'hFFFF_FFFF);
            end else begin
                logic [23:0] e;
                e = sb_q.pop_front();
                check("R7 fetch_tag", {16'h0, fetch_tag}, {16'h0, e[23:8]});
                check("R7 fetch_data", {24'h0, fetch_data}, {24'h0, e[7:0]});
            end
        end
    end

    task automatic do_reset(input logic e, input logic a);
        @(posedge clk); #1;
        rst_n = 1'b0; bus_en = e; ext_acc = a; exp_en = e; exp_ea = a;
        repeat (3) @(posedge clk);
        #1;
        check("R10 ale in reset", {31'h0, ale}, 32'h0);
        check("R10 read strobes in reset", {30'h0, pri_rd_n, alt_rd_n}, 32'h3);
        check("R10 fetch_valid in reset", {31'h0, fetch_valid}, 32'h0);
        rst_n = 1'b1;
        slot_par = 1'b0;
        skip_exp = 1'b0;
        mon_en = 1'b1;
    endtask

    // Driver: run one slot, push the expected fetch, check strobes per clock.
    task automatic run_slot(input logic [15:0] addr, input logic dcyc, input string tag);
        logic sbad, act;
        int route;
        @(negedge clk);
        next_addr = addr;
        if (!slot_par) begin
            data_cycle = dcyc;
            skip_exp = dcyc;
        end
        sbad = !exp_en && exp_ea;
        if (sbad) route = 0;
        else if (!exp_en) route = 1;
        else if (!exp_ea) route = 2;
        else route = (addr[15:13] == 3'b000) ? 2 : 1;
        act = !sbad && !(slot_par && skip_exp);
        if (act) sb_q.push_back({addr, (route == 2) ? op_alt(addr) : op_pri(addr)});
        for (int s = 0; s < 6; s++) begin
            @(posedge clk); #1;
            check({tag, " ale"}, {31'h0, ale}, {31'h0, act && s < 2});
            check({tag, " pri_rd_n"}, {31'h0, pri_rd_n}, {31'h0, !(act && route == 1 && s >= 3)});
            check({tag, " alt_rd_n"}, {31'h0, alt_rd_n}, {31'h0, !(act && route == 2 && s >= 3)});
            if (s == 0 && act && route == 1)
                check({tag, " R5 pri addr"}, {16'h0, pri_hi_out, pri_lo_out}, {16'h0, addr});
            if (s == 0 && act && route == 2)
                check({tag, " R5 alt addr"}, {16'h0, alt_hi_out, alt_lo_out}, {16'h0, addr});
            if (s == 3) begin
                pri_lo_in = op_pri(addr);
                alt_lo_in = op_alt(addr);
            end
        end
        slot_par = !slot_par;
    endtask

    task automatic drain;
        @(posedge clk); #1;
        @(negedge clk); #1;
        check("R7 scoreboard empty", sb_q.size(), 0);
        mon_en = 1'b0;
        sb_q.delete();
    endtask

    initial begin
        mon_en = 1'b0;
        exp_en = 1'b0; exp_ea = 1'b0; slot_par = 1'b0; skip_exp = 1'b0;

        // R1: primary only
        do_reset(1'b0, 1'b0);
        check("R1 strap_bad", {31'h0, strap_bad}, 32'h0);
        run_slot(16'h0123, 1'b0, "R1");
        run_slot(16'h4567, 1'b0, "R1");
        run_slot(16'h1FFF, 1'b1, "R6");
        run_slot(16'hBEEF, 1'b1, "R6 skipped");
        run_slot(16'hFFFF, 1'b0, "R1");
        run_slot(16'h2000, 1'b0, "R1");
        drain();

        // R2: invalid straps
        do_reset(1'b0, 1'b1);
        check("R2 strap_bad", {31'h0, strap_bad}, 32'h1);
        run_slot(16'h0040, 1'b0, "R2");
        run_slot(16'h8040, 1'b0, "R2");
        drain();

        // R3: alternate only
        do_reset(1'b1, 1'b0);
        run_slot(16'h1000, 1'b0, "R3");
        run_slot(16'hA5A5, 1'b0, "R3");
        run_slot(16'h3C3C, 1'b1, "R3");
        run_slot(16'h7777, 1'b1, "R6 skipped");
        drain();

        // R4: split at 2000H; R8: strap pins changed while running
        do_reset(1'b1, 1'b1);
        run_slot(16'h1FFF, 1'b0, "R4 below");
        run_slot(16'h2000, 1'b0, "R4 at");
        run_slot(16'h0000, 1'b1, "R4 zero");
        run_slot(16'hE001, 1'b1, "R6 skipped");
        bus_en = 1'b0; ext_acc = 1'b1;
        run_slot(16'h0ABC, 1'b0, "R8 held");
        run_slot(16'hC0DE, 1'b0, "R8 held");
        check("R8 strap_bad stays low", {31'h0, strap_bad}, 32'h0);
        drain();

        // R9: alternate ports as registers
        do_reset(1'b0, 1'b0);
        mon_en = 1'b0;
        check("R9 lo reset", {24'h0, alt_lo_out}, 32'hFF);
        check("R9 hi reset", {24'h0, alt_hi_out}, 32'hFF);
        @(negedge clk); sfr_we = 1'b1; sfr_addr = 8'h91; sfr_wdata = 8'h3C;
        @(negedge clk); sfr_addr = 8'hA1; sfr_wdata = 8'h7E;
        @(negedge clk); sfr_addr = 8'h90; sfr_wdata = 8'h00;
        @(negedge clk); sfr_we = 1'b0; sfr_addr = 8'h91;
        #1;
        check("R9 alt_lo_out", {24'h0, alt_lo_out}, 32'h3C);
        check("R9 alt_hi_out", {24'h0, alt_hi_out}, 32'h7E);
        check("R9 readback 91H", {24'h0, sfr_rdata}, 32'h3C);
        sfr_addr = 8'hA1; #1;
        check("R9 readback A1H", {24'h0, sfr_rdata}, 32'h7E);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule